// File: doc/BRIEF.md
# Layered Automaton Track Pattern Matcher

This block holds a bank of small automaton chains, one per stored track pattern, and runs all of them at once against a stream of 8-bit detector symbols. Each chain first qualifies a calorimeter cluster. The cluster energy must fall inside the chain's allowed range, and the cluster coordinate must equal the chain's stored coordinate. The chain then looks for one 16-bit hit address in each of four detector layers, taken in order. Every chain sees every valid symbol in the same cycle, so the time to reach a result depends on the number of symbols and not on the size of the bank.

A symbol carries a layer tag. Tag 0 marks a cluster symbol, and tags 1 to 4 mark hits in layers 1 to 4. A parity phase pairs consecutive valid symbols. The even symbol carries the energy or the address high byte. The odd symbol carries the coordinate or the address low byte. A layer stage stays set once it has matched, so the hits inside a layer may arrive in any order. A start-of-event pulse clears all match state. An end-of-event pulse captures the chains that completed all four layers and lists their indices, lowest first, one per cycle.

The pattern bank is loaded through a write port that writes one field per cycle.

Top module: `tnfa_matcher`

## Requirements
- R1: After reset, and until an end-of-event pulse captures a completed chain, `rpt_valid` stays low. An end-of-event pulse that arrives with no completed chain produces no report.
- R2: The cluster stage of a chain is satisfied only when two consecutive valid tag-0 symbols match it. The even-phase symbol (energy E) must satisfy lo <= E <= hi, with both bounds inclusive. The odd-phase symbol must equal the stored coordinate.
- R3: A layer address matches only when two consecutive valid symbols with the same layer tag match it. The even-phase symbol must equal bits 15:8 of the stored address and the odd-phase symbol must equal bits 7:0. A byte-swapped address does not match.
- R4: A layer-k stage can start a match only while stage k-1 is set. Stage 0 is the cluster stage. Once set, a stage stays set until the next start-of-event, whatever other hits of the layer follow.
- R5: On an end-of-event pulse the block captures every chain whose layer-4 stage is set. From the next cycle on, it presents each captured index on `rpt_idx` with `rpt_valid` high, one index per cycle, in ascending order.
- R6: A cycle with `sym_valid` low changes neither the parity phase nor any chain state, whatever its data and tag.
- R7: A start-of-event pulse clears every chain stage and returns the phase to even. A symbol presented in the same cycle is ignored.
- R8: The first report appears in the cycle after the end-of-event pulse, however many patterns are stored or completed.
- R9: A write with `cfg_we` high sets one field of the chain selected by `cfg_idx`. The field codes are: 0 energy low bound (data bits 7:0), 1 energy high bound, 2 coordinate, 3 to 6 the address for layers 1 to 4. Code 7 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Pattern field write enable |
| cfg_idx | input | 4 | Chain selected by the write |
| cfg_field | input | 3 | Field code of the write |
| cfg_data | input | 16 | Write data |
| sof | input | 1 | Start-of-event pulse |
| eoe | input | 1 | End-of-event pulse |
| sym_valid | input | 1 | Symbol qualifier |
| sym_layer | input | 3 | Symbol tag: 0 cluster, 1 to 4 layer |
| sym_data | input | 8 | Symbol byte |
| rpt_valid | output | 1 | Report index is valid |
| rpt_idx | output | 4 | Index of a completed chain |

## Verification
The hardest situations to reach are those where one symbol lands in the wrong half of a pair. Examples are a low byte that arrives without its high byte, bytes in swapped order, and an idle cycle whose data would match if the phase had moved. The bench reaches these by inserting invalid cycles with matching data between the two halves of an address, and by storing one pattern whose layer-1 address is the byte swap of another pattern's. Hits for a later layer are also sent before the earlier layer, so that an unlatched stage has to refuse a match that looks correct.

// File: rtl/tnfa_pkg.sv
package tnfa_pkg;
    localparam int SYM_W   = 8;
    localparam int ADDR_W  = 16;
    localparam int NLAYER  = 4;
    localparam int LAYER_W = 3;
    localparam int FIELD_W = 3;

    typedef enum logic [FIELD_W-1:0] {
        FLD_E_LO  = 3'd0,
        FLD_E_HI  = 3'd1,
        FLD_COORD = 3'd2,
        FLD_ADDR1 = 3'd3,
        FLD_ADDR2 = 3'd4,
        FLD_ADDR3 = 3'd5,
        FLD_ADDR4 = 3'd6,
        FLD_NONE  = 3'd7
    } cfg_field_e;

    typedef struct packed {
        logic [NLAYER-1:0][ADDR_W-1:0] addr;
        logic [SYM_W-1:0]              coord;
        logic [SYM_W-1:0]              e_hi;
        logic [SYM_W-1:0]              e_lo;
    } pattern_t;
endpackage

// File: rtl/tnfa_chain.sv
module tnfa_chain
    import tnfa_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_field,
    input  logic [ADDR_W-1:0]  wr_data,
    input  logic               sof,
    input  logic               sym_valid,
    input  logic               sym_odd,
    input  logic [LAYER_W-1:0] sym_layer,
    input  logic [SYM_W-1:0]   sym_data,
    output logic               done
);
    typedef struct packed {
        pattern_t          pat;
        logic [NLAYER:0]   half;
        logic [NLAYER:0]   lat;
    } chain_st_t;

    chain_st_t q, d;

    logic [NLAYER:0] hi_hit;
    logic [NLAYER:0] lo_hit;
    logic [NLAYER:0] en;

    assign hi_hit[0] = (sym_data >= q.pat.e_lo) && (sym_data <= q.pat.e_hi);
    assign lo_hit[0] = (sym_data == q.pat.coord);
    assign en[0]     = 1'b1;

    for (genvar k = 1; k <= NLAYER; k++) begin : g_stage
        assign hi_hit[k] = (sym_data == q.pat.addr[k-1][ADDR_W-1:SYM_W]);
        assign lo_hit[k] = (sym_data == q.pat.addr[k-1][SYM_W-1:0]);
        assign en[k]     = q.lat[k-1];
    end

    always_comb begin
        d = q;
        if (wr_en) begin
            case (cfg_field_e'(wr_field))
                FLD_E_LO:  d.pat.e_lo    = wr_data[SYM_W-1:0];
                FLD_E_HI:  d.pat.e_hi    = wr_data[SYM_W-1:0];
                FLD_COORD: d.pat.coord   = wr_data[SYM_W-1:0];
                FLD_ADDR1: d.pat.addr[0] = wr_data;
                FLD_ADDR2: d.pat.addr[1] = wr_data;
                FLD_ADDR3: d.pat.addr[2] = wr_data;
                FLD_ADDR4: d.pat.addr[3] = wr_data;
                default:   ;
            endcase
        end
        if (sof) begin
            d.half = '0;
            d.lat  = '0;
        end else if (sym_valid) begin
            d.half = '0;
            for (int t = 0; t <= NLAYER; t++) begin
                if (sym_layer == LAYER_W'(t)) begin
                    if (!sym_odd) begin
                        d.half[t] = en[t] && hi_hit[t] && !q.lat[t];
                    end else if (q.half[t] && lo_hit[t]) begin
                        d.lat[t] = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.lat[NLAYER];

    for (genvar k = 1; k <= NLAYER; k++) begin : g_chk
        AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            q.lat[k] |-> q.lat[k-1]); // R4
        AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            q.lat[k] && !sof |=> q.lat[k]); // R4
    end

    AST_PAIR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.lat[1]) |-> $past(sym_valid && sym_odd && sym_layer == LAYER_W'(1))); // R3

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid && !sof |=> $stable(q.lat) && q.half == '0 || $stable(q.half)); // R6

    AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> q.lat == '0); // R7
endmodule

// File: rtl/tnfa_drain.sv
module tnfa_drain #(
    parameter int NPAT  = 16,
    localparam int IDX_W = (NPAT > 1) ? $clog2(NPAT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoe,
    input  logic [NPAT-1:0]  done,
    output logic             rpt_valid,
    output logic [IDX_W-1:0] rpt_idx
);
    typedef struct packed {
        logic [NPAT-1:0] pend;
    } drain_st_t;

    drain_st_t q, d;

    always_comb begin
        rpt_idx = '0;
        for (int i = NPAT - 1; i >= 0; i--) begin
            if (q.pend[i]) rpt_idx = IDX_W'(i);
        end
    end

    assign rpt_valid = |q.pend;

    always_comb begin
        d = q;
        if (eoe)            d.pend = done;
        else if (rpt_valid) d.pend = q.pend & (q.pend - NPAT'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid && !eoe |=> $countones(q.pend) == $countones($past(q.pend)) - 1); // R5

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        eoe |=> q.pend == $past(done)); // R8
endmodule

// File: rtl/tnfa_matcher.sv
module tnfa_matcher
    import tnfa_pkg::*;
#(
    parameter int NPAT  = 16,
    localparam int IDX_W = (NPAT > 1) ? $clog2(NPAT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [FIELD_W-1:0] cfg_field,
    input  logic [ADDR_W-1:0]  cfg_data,
    input  logic               sof,
    input  logic               eoe,
    input  logic               sym_valid,
    input  logic [LAYER_W-1:0] sym_layer,
    input  logic [SYM_W-1:0]   sym_data,
    output logic               rpt_valid,
    output logic [IDX_W-1:0]   rpt_idx
);
    typedef struct packed {
        logic odd;
    } phase_st_t;

    phase_st_t ph_q, ph_d;

    always_comb begin
        ph_d = ph_q;
        if (sof)            ph_d.odd = 1'b0;
        else if (sym_valid) ph_d.odd = !ph_q.odd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    logic [NPAT-1:0] done;

    for (genvar p = 0; p < NPAT; p++) begin : g_chain
        tnfa_chain u_chain (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we && (cfg_idx == IDX_W'(p))),
            .wr_field  (cfg_field),
            .wr_data   (cfg_data),
            .sof       (sof),
            .sym_valid (sym_valid),
            .sym_odd   (ph_q.odd),
            .sym_layer (sym_layer),
            .sym_data  (sym_data),
            .done      (done[p])
        );
    end

    tnfa_drain #(.NPAT(NPAT)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .eoe       (eoe),
        .done      (done),
        .rpt_valid (rpt_valid),
        .rpt_idx   (rpt_idx)
    );

    AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid && !sof |=> $stable(ph_q.odd)); // R6

    AST_PHASE_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !ph_q.odd); // R7

    AST_REPORT_AFTER_EOE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rpt_valid) |-> $past(eoe)); // R1
endmodule

// File: tb/test_tnfa_matcher.sv
module test_tnfa_matcher;
    localparam int NP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [2:0]  cfg_field = '0;
    logic [15:0] cfg_data = '0;
    logic        sof = 1'b0;
    logic        eoe = 1'b0;
    logic        sym_valid = 1'b0;
    logic [2:0]  sym_layer = '0;
    logic [7:0]  sym_data = '0;
    logic        rpt_valid;
    logic [3:0]  rpt_idx;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    tnfa_matcher i_tnfa_matcher (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_field(cfg_field), .cfg_data(cfg_data), .sof(sof), .eoe(eoe),
        .sym_valid(sym_valid), .sym_layer(sym_layer), .sym_data(sym_data),
        .rpt_valid(rpt_valid), .rpt_idx(rpt_idx)
    );

    // behavioural reference
    int m_lo[NP], m_hi[NP], m_co[NP], m_ad[NP][4];
    int m_stage[NP];
    int m_pend[NP];
    bit m_odd;
    int m_q[$];

    bit [15:0] got_mask;
    int        got_cnt;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_q.delete();
            m_odd = 1'b0;
            for (int p = 0; p < NP; p++) begin
                m_stage[p] = 0;
                m_pend[p] = -1;
                m_lo[p] = 0; m_hi[p] = 0; m_co[p] = 0;
                for (int k = 0; k < 4; k++) m_ad[p][k] = 0;
            end
        end else begin
            if (eoe) begin
                m_q.delete();
                for (int p = 0; p < NP; p++) if (m_stage[p] == 5) m_q.push_back(p);
            end else if (m_q.size() > 0) begin
                void'(m_q.pop_front());
            end
            if (cfg_we) begin
                case (cfg_field)
                    3'd0: m_lo[cfg_idx] = cfg_data[7:0];
                    3'd1: m_hi[cfg_idx] = cfg_data[7:0];
                    3'd2: m_co[cfg_idx] = cfg_data[7:0];
                    3'd3, 3'd4, 3'd5, 3'd6: m_ad[cfg_idx][cfg_field-3] = cfg_data;
                    default: ;
                endcase
            end
            if (sof) begin
                m_odd = 1'b0;
                for (int p = 0; p < NP; p++) begin m_stage[p] = 0; m_pend[p] = -1; end
            end else if (sym_valid) begin
                for (int p = 0; p < NP; p++) begin
                    int t, np_;
                    bit hi_ok, lo_ok;
                    t = sym_layer;
                    np_ = -1;
                    if (t == 0) begin
                        hi_ok = (sym_data >= m_lo[p]) && (sym_data <= m_hi[p]);
                        lo_ok = (sym_data == m_co[p]);
                    end else if (t <= 4) begin
                        hi_ok = (sym_data == m_ad[p][t-1][15:8]);
                        lo_ok = (sym_data == m_ad[p][t-1][7:0]);
                    end else begin
                        hi_ok = 0; lo_ok = 0;
                    end
                    if (!m_odd) begin
                        if (m_stage[p] == t && hi_ok) np_ = t;
                    end else if (m_pend[p] == t && lo_ok) begin
                        m_stage[p] = t + 1;
                    end
                    m_pend[p] = np_;
                end
                m_odd = !m_odd;
            end
        end
        #4;
        if (rst_n) begin
            // cycle-exact report stream: R5 ordering, R8 first index one cycle after eoe
            chk("R5/R8 rpt_valid", int'(rpt_valid), int'(m_q.size() > 0));
            if (rpt_valid && m_q.size() > 0) chk("R5/R8 rpt_idx", int'(rpt_idx), m_q[0]);
            if (rpt_valid) begin
                got_mask[rpt_idx] = 1'b1;
                got_cnt++;
            end
        end
    end

    task automatic drive(bit v, int l, int dat, bit s, bit e);
        @(negedge clk);
        cfg_we = 1'b0;
        sym_valid = v;
        sym_layer = 3'(l);
        sym_data = 8'(dat);
        sof = s;
        eoe = e;
    endtask

    task automatic wr(int p, int f, int dat);
        @(negedge clk);
        sym_valid = 1'b0; sof = 1'b0; eoe = 1'b0;
        cfg_we = 1'b1;
        cfg_idx = 4'(p);
        cfg_field = 3'(f);
        cfg_data = 16'(dat);
    endtask

    task automatic load(int p, int lo, int hi, int co, int a1, int a2, int a3, int a4);
        wr(p, 0, lo); wr(p, 1, hi); wr(p, 2, co);
        wr(p, 3, a1); wr(p, 4, a2); wr(p, 5, a3); wr(p, 6, a4);
    endtask

    task automatic hit(int l, int a);
        drive(1, l, a >> 8, 0, 0);
        drive(1, l, a & 8'hff, 0, 0);
    endtask

    task automatic start_ev(int e, int co);
        drive(0, 0, 0, 1, 0);
        hit(0, (e << 8) | co);
    endtask

    task automatic finish_ev(string req, bit [15:0] exp);
        drive(0, 0, 0, 0, 0);
        got_mask = '0;
        got_cnt = 0;
        drive(0, 0, 0, 0, 1);
        for (int i = 0; i < 20; i++) drive(0, 0, 0, 0, 0);
        chk({req, " mask"}, int'(got_mask), int'(exp));
        chk({req, " count"}, got_cnt, $countones(exp));
    endtask

    task automatic track_rest(int a2, int a3, int a4);
        hit(2, a2); hit(3, a3); hit(4, a4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rpt_valid", int'(rpt_valid), 0);
        finish_ev("R1 empty eoe", 16'h0000);

        // R9 bank loading via field codes
        load(0, 10, 20, 8'h33, 16'h1234, 16'h2345, 16'h3456, 16'h4567);
        load(1, 10, 20, 8'h33, 16'h1234, 16'h2345, 16'h3457, 16'h4567);
        load(2, 50, 60, 8'h33, 16'h1234, 16'h2345, 16'h3456, 16'h4567);
        load(3, 10, 20, 8'h44, 16'h1234, 16'h2345, 16'h3456, 16'h4567);
        load(4, 10, 20, 8'h33, 16'h3412, 16'h2345, 16'h3456, 16'h4567);
        for (int p = 5; p < NP; p++)
            load(p, 200, 199, 0, p * 16'h0101, p * 16'h0101, p * 16'h0101, p * 16'h0101);

        // R2 upper bound, R4 unordered hits within layers
        start_ev(20, 8'h33);
        hit(1, 16'h9999); hit(1, 16'h1234); hit(1, 16'h0000);
        hit(2, 16'h2345);
        hit(3, 16'h1111); hit(3, 16'h3456); hit(3, 16'h3457);
        hit(4, 16'h4567);
        finish_ev("R2 R4 event A", 16'h0003);

        // R2 lower bound and out of range
        start_ev(50, 8'h33);
        hit(1, 16'h1234); track_rest(16'h2345, 16'h3456, 16'h4567);
        finish_ev("R2 low bound", 16'h0004);
        start_ev(61, 8'h33);
        hit(1, 16'h1234); track_rest(16'h2345, 16'h3456, 16'h4567);
        finish_ev("R2 above range", 16'h0000);

        // R4 later layer before earlier one
        start_ev(15, 8'h33);
        hit(2, 16'h2345); hit(1, 16'h1234); hit(3, 16'h3456); hit(4, 16'h4567);
        finish_ev("R4 layer order", 16'h0000);

        // R6 idle cycles between the halves of an address
        start_ev(15, 8'h33);
        drive(1, 1, 8'h12, 0, 0);
        drive(0, 1, 8'h34, 0, 0);
        drive(0, 1, 8'h12, 0, 0);
        drive(1, 1, 8'h34, 0, 0);
        drive(0, 2, 8'h23, 0, 0);
        track_rest(16'h2345, 16'h3456, 16'h4567);
        finish_ev("R6 idle gaps", 16'h0001);

        // R3 byte swapped address
        start_ev(15, 8'h33);
        hit(1, 16'h3412); track_rest(16'h2345, 16'h3456, 16'h4567);
        finish_ev("R3 swapped bytes", 16'h0010);

        // R7 start-of-event in the middle, with a symbol in the same cycle
        start_ev(15, 8'h33);
        hit(1, 16'h1234);
        drive(1, 2, 8'h23, 1, 0);
        hit(2, 16'h2345); hit(3, 16'h3456); hit(4, 16'h4567);
        finish_ev("R7 mid clear", 16'h0000);

        // R9 rewrite coordinate of chain 3, code 7 on chain 0 writes nothing
        wr(3, 2, 8'h33);
        wr(0, 7, 16'h0000);
        start_ev(20, 8'h33);
        hit(1, 16'h1234); hit(2, 16'h2345); hit(3, 16'h3456); hit(3, 16'h3457);
        hit(4, 16'h4567);
        finish_ev("R9 field write", 16'h000B);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule